// File: doc/BRIEF.md
# Pixel Row Steering Sequencer

This block steps through the rows of a pixel sensor matrix that is read out one row at a time. For every row it visits, it plays a short control pattern. That pattern is held in a small writable step store, so the sequence is flexible. Each step names the control lines it raises and how many clock cycles it lasts. A typical row pattern does the following, in order:

- switch the row on;
- take a sample while the collected charge is still present;
- pulse the row's clear line;
- take a second sample of the now-empty row;
- switch the row off.

The two samples go to the readout, which subtracts one from the other.

One instance serves 64 rows. A scan can begin at any row and cover a chosen number of rows, which gives random access to a region of the matrix. Instances form a chain. An instance hands its scan on to the next one when the scan needs a row beyond its last row. A chain pulse arriving at an idle instance makes it scan from its first row to its last and then pass the chain pulse on.

Top module: `row_steer_seq`

## Requirements
- R1: During and directly after reset, every row gate and row clear output, both sample outputs, `busy`, `scan_done` and `chain_out` are low, and every step of the pattern store reads as control 0 with duration 0.
- R2: A write on `pat_we` stores a control vector and a duration into the step addressed by `pat_addr`, and later row patterns use the stored values.
- R3: Each step with duration d > 0 presents its control vector for exactly d cycles. Steps run in index order from step 0. Control bit 0 raises the gate of the current row, bit 1 raises its clear line, bit 2 raises `smp_full` and bit 3 raises `smp_empty`.
- R4: A step with duration 0 ends the row pattern, and so does running past step 15. Ending costs one cycle with all control outputs low. The next row then starts at step 0, and steps after the terminating one are never played.
- R5: The clear line of a row is never raised in a cycle in which either sample output is high. A step that asks for both clear and a sample gives only the sample.
- R6: At most one row gate output and at most one row clear output are high in any cycle.
- R7: A `scan_go` pulse in idle starts a scan at row `scan_first`, covering `scan_extra`+1 rows in increasing order. Step 0 of the first row appears in the cycle after the sampling edge, and `busy` stays high until the scan ends.
- R8: When the last requested row lies at or below row 63, `scan_done` is a one-cycle pulse in the cycle after that row's ending cycle.
- R9: When a scan needs a row beyond 63, the instance stops after row 63 and raises `chain_out` for one cycle instead of `scan_done`. `chain_out` is never raised otherwise.
- R10: A `chain_in` pulse in idle starts a scan at row 0 that runs through row 63 and ends with a `chain_out` pulse.
- R11: `scan_go` and `chain_in` are ignored while `busy` is high, and `scan_go` takes priority when both arrive together in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pat_we | input | 1 | Pattern store write strobe |
| pat_addr | input | 4 | Step index written |
| pat_ctl | input | 4 | Step control vector (bit0 gate, bit1 clear, bit2 full sample, bit3 empty sample) |
| pat_dur | input | 8 | Step duration in cycles; 0 ends the row |
| scan_go | input | 1 | Start a region scan |
| scan_first | input | 6 | First row of the region |
| scan_extra | input | 6 | Number of rows minus one |
| chain_in | input | 1 | Chain pulse from the previous instance |
| row_gate | output | 64 | Per-row gate (row on) lines |
| row_clr | output | 64 | Per-row clear lines |
| smp_full | output | 1 | Sample strobe with collected charge |
| smp_empty | output | 1 | Sample strobe after clearing |
| busy | output | 1 | A scan is running |
| scan_done | output | 1 | One-cycle end-of-region pulse |
| chain_out | output | 1 | One-cycle pulse to the next instance |

## Verification
A row built from steps of durations d0..dk lasts their sum plus one ending cycle, L in total. Counting i edges after the edge that sampled the start, the outputs belong to row i/L and to the step that contains offset i mod L. `scan_done` or `chain_out` is due exactly at i = N·L, where N is the number of rows actually visited, and it must be low again one cycle later. The bench computes this position arithmetically and compares every output once per cycle, sampling at the falling edge.

// File: rtl/rowseq_pkg.sv
package rowseq_pkg;
   localparam int CTL_W  = 4;
   localparam int GATE_B = 0;
   localparam int CLR_B  = 1;
   localparam int FULL_B = 2;
   localparam int EMPT_B = 3;

   typedef enum logic {
      SQ_IDLE = 1'b0,
      SQ_RUN  = 1'b1
   } seq_state_e;
endpackage

// File: rtl/rowseq_patmem.sv
module rowseq_patmem
   import rowseq_pkg::*;
#(
   parameter int STEPS = 16,
   parameter int DUR_W = 8,
   localparam int STEP_W = $clog2(STEPS),
   localparam int SI_W   = STEP_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [STEP_W-1:0] wr_idx,
   input  logic [CTL_W-1:0]  wr_ctl,
   input  logic [DUR_W-1:0]  wr_dur,
   input  logic [SI_W-1:0]   rd_idx,
   output logic [CTL_W-1:0]  rd_ctl,
   output logic [DUR_W-1:0]  rd_dur
);
   localparam logic [SI_W-1:0] STEP_END = SI_W'(STEPS);

   logic [CTL_W-1:0] ctl_q [STEPS];
   logic [DUR_W-1:0] dur_q [STEPS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < STEPS; s++) begin
            ctl_q[s] <= '0;
            dur_q[s] <= '0;
         end
      end else if (wr_en) begin
         ctl_q[wr_idx] <= wr_ctl;
         dur_q[wr_idx] <= wr_dur;
      end
   end

   // an index past the last step reads as a terminating step
   always_comb begin
      rd_ctl = '0;
      rd_dur = '0;
      if (rd_idx < STEP_END) begin
         rd_ctl = ctl_q[rd_idx[STEP_W-1:0]];
         rd_dur = dur_q[rd_idx[STEP_W-1:0]];
      end
   end

   // R2
   write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !$isunknown(wr_idx)) |=> (ctl_q[$past(wr_idx)] == $past(wr_ctl)));
endmodule

// File: rtl/rowseq_ctrl.sv
module rowseq_ctrl
   import rowseq_pkg::*;
#(
   parameter int NUM_ROWS = 64,
   parameter int STEPS    = 16,
   parameter int DUR_W    = 8,
   localparam int ROW_W  = $clog2(NUM_ROWS),
   localparam int STEP_W = $clog2(STEPS),
   localparam int SI_W   = STEP_W + 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             go,
   input  logic [ROW_W-1:0] go_row,
   input  logic [ROW_W-1:0] go_extra,
   input  logic             link_in,
   input  logic [DUR_W-1:0] step_dur,
   output logic [SI_W-1:0]  step_idx,
   output logic [ROW_W-1:0] row_idx,
   output logic             step_live,
   output logic             running,
   output logic             fin_pulse,
   output logic             link_pulse
);
   localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(NUM_ROWS - 1);

   seq_state_e       st_q;
   logic [ROW_W-1:0] row_q;
   logic [ROW_W-1:0] left_q;
   logic             chain_q;
   logic [SI_W-1:0]  step_q;
   logic [DUR_W-1:0] cnt_q;
   logic             fin_q;
   logic             link_q;

   logic end_mark;
   logic step_last;

   assign end_mark  = (step_dur == '0);
   assign step_last = (cnt_q == step_dur - DUR_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= SQ_IDLE;
         row_q   <= '0;
         left_q  <= '0;
         chain_q <= 1'b0;
         step_q  <= '0;
         cnt_q   <= '0;
         fin_q   <= 1'b0;
         link_q  <= 1'b0;
      end else begin
         fin_q  <= 1'b0;
         link_q <= 1'b0;
         unique case (st_q)
            SQ_IDLE: begin
               step_q <= '0;
               cnt_q  <= '0;
               if (go) begin
                  st_q    <= SQ_RUN;
                  row_q   <= go_row;
                  left_q  <= go_extra;
                  chain_q <= 1'b0;
               end else if (link_in) begin
                  st_q    <= SQ_RUN;
                  row_q   <= '0;
                  left_q  <= '0;
                  chain_q <= 1'b1;
               end
            end
            SQ_RUN: begin
               if (end_mark) begin
                  step_q <= '0;
                  cnt_q  <= '0;
                  if (!chain_q && left_q == '0) begin
                     st_q  <= SQ_IDLE;
                     fin_q <= 1'b1;
                  end else if (row_q == ROW_LAST) begin
                     st_q   <= SQ_IDLE;
                     link_q <= 1'b1;
                  end else begin
                     row_q  <= row_q + ROW_W'(1);
                     left_q <= left_q - ROW_W'(1);
                  end
               end else if (step_last) begin
                  step_q <= step_q + SI_W'(1);
                  cnt_q  <= '0;
               end else begin
                  cnt_q <= cnt_q + DUR_W'(1);
               end
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign running    = (st_q == SQ_RUN);
   assign step_live  = running && !end_mark;
   assign step_idx   = step_q;
   assign row_idx    = row_q;
   assign fin_pulse  = fin_q;
   assign link_pulse = link_q;

   // R7
   go_loads_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && go) |=> (running && row_q == $past(go_row)));

   // R10
   link_starts_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !go && link_in) |=> (running && row_q == '0));

   // R11
   busy_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !end_mark) |=> (running && $stable(row_q)));

   // R8
   fin_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fin_q |=> !fin_q);

   // R9
   link_last_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
      link_q |-> ($past(row_q) == ROW_LAST && !fin_q && !running));
endmodule

// File: rtl/rowseq_drive.sv
module rowseq_drive
   import rowseq_pkg::*;
#(
   parameter int NUM_ROWS = 64,
   localparam int ROW_W = $clog2(NUM_ROWS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                live,
   input  logic [ROW_W-1:0]    row_idx,
   input  logic [CTL_W-1:0]    ctl,
   output logic [NUM_ROWS-1:0] gate_o,
   output logic [NUM_ROWS-1:0] clr_o,
   output logic                full_o,
   output logic                empt_o
);
   logic want_gate;
   logic want_clr;

   assign full_o    = live && ctl[FULL_B];
   assign empt_o    = live && ctl[EMPT_B];
   assign want_gate = live && ctl[GATE_B];
   // a sample step always wins over a clear request
   assign want_clr  = live && ctl[CLR_B] && !ctl[FULL_B] && !ctl[EMPT_B];

   for (genvar r = 0; r < NUM_ROWS; r++) begin : g_row
      assign gate_o[r] = want_gate && (row_idx == ROW_W'(r));
      assign clr_o[r]  = want_clr  && (row_idx == ROW_W'(r));
   end

   // R6
   one_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gate_o));

   // R6
   one_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(clr_o));

   // R5
   clr_vs_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|clr_o) |-> !(full_o || empt_o));
endmodule

// File: rtl/row_steer_seq.sv
module row_steer_seq
   import rowseq_pkg::*;
#(
   parameter int NUM_ROWS = 64,
   parameter int STEPS    = 16,
   parameter int DUR_W    = 8,
   localparam int ROW_W  = $clog2(NUM_ROWS),
   localparam int STEP_W = $clog2(STEPS),
   localparam int SI_W   = STEP_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                pat_we,
   input  logic [STEP_W-1:0]   pat_addr,
   input  logic [CTL_W-1:0]    pat_ctl,
   input  logic [DUR_W-1:0]    pat_dur,
   input  logic                scan_go,
   input  logic [ROW_W-1:0]    scan_first,
   input  logic [ROW_W-1:0]    scan_extra,
   input  logic                chain_in,
   output logic [NUM_ROWS-1:0] row_gate,
   output logic [NUM_ROWS-1:0] row_clr,
   output logic                smp_full,
   output logic                smp_empty,
   output logic                busy,
   output logic                scan_done,
   output logic                chain_out
);
   if (NUM_ROWS < 2 || (NUM_ROWS & (NUM_ROWS - 1)) != 0) begin : g_bad_rows
      $error("row_steer_seq: NUM_ROWS must be a power of two, at least 2");
   end
   if (STEPS < 2 || (STEPS & (STEPS - 1)) != 0) begin : g_bad_steps
      $error("row_steer_seq: STEPS must be a power of two, at least 2");
   end
   if (DUR_W < 1) begin : g_bad_dur
      $error("row_steer_seq: DUR_W must be positive");
   end

   logic [SI_W-1:0]  step_idx;
   logic [ROW_W-1:0] row_idx;
   logic [CTL_W-1:0] step_ctl;
   logic [DUR_W-1:0] step_dur;
   logic             step_live;

   rowseq_patmem #(.STEPS(STEPS), .DUR_W(DUR_W)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (pat_we),
      .wr_idx (pat_addr),
      .wr_ctl (pat_ctl),
      .wr_dur (pat_dur),
      .rd_idx (step_idx),
      .rd_ctl (step_ctl),
      .rd_dur (step_dur)
   );

   rowseq_ctrl #(.NUM_ROWS(NUM_ROWS), .STEPS(STEPS), .DUR_W(DUR_W)) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .go         (scan_go),
      .go_row     (scan_first),
      .go_extra   (scan_extra),
      .link_in    (chain_in),
      .step_dur   (step_dur),
      .step_idx   (step_idx),
      .row_idx    (row_idx),
      .step_live  (step_live),
      .running    (busy),
      .fin_pulse  (scan_done),
      .link_pulse (chain_out)
   );

   rowseq_drive #(.NUM_ROWS(NUM_ROWS)) u_drive (
      .clk     (clk),
      .rst_n   (rst_n),
      .live    (step_live),
      .row_idx (row_idx),
      .ctl     (step_ctl),
      .gate_o  (row_gate),
      .clr_o   (row_clr),
      .full_o  (smp_full),
      .empt_o  (smp_empty)
   );

   // R8
   done_xor_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(scan_done && chain_out));

   // R4
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (row_gate == '0 && row_clr == '0 && !smp_full && !smp_empty));
endmodule

// File: tb/sim_row_steer_seq.sv
module sim_row_steer_seq;
   localparam int NR = 64;
   localparam int NS = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          pat_we;
   logic [3:0]    pat_addr;
   logic [3:0]    pat_ctl;
   logic [DW-1:0] pat_dur;
   logic          scan_go;
   logic [5:0]    scan_first;
   logic [5:0]    scan_extra;
   logic          chain_in;
   logic [NR-1:0] row_gate;
   logic [NR-1:0] row_clr;
   logic          smp_full;
   logic          smp_empty;
   logic          busy;
   logic          scan_done;
   logic          chain_out;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  finished = 0;
   int  pd [NS];
   int  pc [NS];

   always #2 clk = ~clk;

   row_steer_seq u0 (
      .clk(clk), .rst_n(rst_n), .pat_we(pat_we), .pat_addr(pat_addr),
      .pat_ctl(pat_ctl), .pat_dur(pat_dur), .scan_go(scan_go),
      .scan_first(scan_first), .scan_extra(scan_extra), .chain_in(chain_in),
      .row_gate(row_gate), .row_clr(row_clr), .smp_full(smp_full),
      .smp_empty(smp_empty), .busy(busy), .scan_done(scan_done),
      .chain_out(chain_out)
   );

   task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
      end
   endtask

   // R2: write one step at a falling edge, strobe removed one cycle later
   task automatic put_step(input int s, input int c, input int d);
      pat_we = 1'b1; pat_addr = 4'(s); pat_ctl = 4'(c); pat_dur = DW'(d);
      pd[s] = d; pc[s] = c;
      @(negedge clk);
      pat_we = 1'b0;
   endtask

   function automatic int row_len();
      int sum = 0;
      for (int s = 0; s < NS; s++) begin
         if (pd[s] == 0) break;
         sum += pd[s];
      end
      return sum + 1;
   endfunction

   function automatic int ctl_at(input int off);
      int p = off;
      for (int s = 0; s < NS; s++) begin
         if (pd[s] == 0) return 0;
         if (p < pd[s]) return pc[s];
         p -= pd[s];
      end
      return 0;
   endfunction

   // called at a falling edge; returns at the falling edge one cycle after the end pulse
   task automatic run_scan(input int sr, input int cnt, input bit use_go,
                           input bit use_chain, input bit poke);
      int L, N, r0, c, row;
      bit tokx;
      logic [63:0] eg, ec;
      L = row_len();
      if (use_go) begin
         r0   = sr;
         N    = (cnt + 1 < NR - sr) ? cnt + 1 : NR - sr;
         tokx = (cnt + 1 > NR - sr);
      end else begin
         r0 = 0; N = NR; tokx = 1'b1;
      end
      scan_go = use_go; chain_in = use_chain;
      scan_first = 6'(sr); scan_extra = 6'(cnt);
      @(negedge clk);
      scan_go = 1'b0; chain_in = 1'b0;
      for (int i = 0; i <= N * L + 1; i++) begin
         if (i > 0) @(negedge clk);
         if (poke && i == 3) begin
            scan_go = 1'b1; chain_in = 1'b1; scan_first = 6'(sr ^ 5); scan_extra = 6'd0;
         end else if (poke && i == 4) begin
            scan_go = 1'b0; chain_in = 1'b0;
         end
         c   = (i / L < N) ? ctl_at(i % L) : 0;
         row = r0 + i / L;
         eg  = c[0] ? (64'd1 << row) : 64'd0;
         ec  = (c[1] && !c[2] && !c[3]) ? (64'd1 << row) : 64'd0;
         chk("R3 row gate", row_gate, eg);
         chk("R5 row clear", row_clr, ec);
         chk("R3 full sample", 64'(smp_full), 64'(c[2]));
         chk("R3 empty sample", 64'(smp_empty), 64'(c[3]));
         chk(poke ? "R11 busy" : "R7 busy", 64'(busy), 64'(i < N * L));
         chk("R8 scan_done", 64'(scan_done), 64'(i == N * L && !tokx));
         chk(use_go ? "R9 chain_out" : "R10 chain_out", 64'(chain_out), 64'(i == N * L && tokx));
      end
   endtask

   initial begin
      rst_n = 1'b0; pat_we = 1'b0; pat_addr = '0; pat_ctl = '0; pat_dur = '0;
      scan_go = 1'b0; scan_first = '0; scan_extra = '0; chain_in = 1'b0;
      for (int s = 0; s < NS; s++) begin pd[s] = 0; pc[s] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 gate in reset", row_gate, 64'd0);
      chk("R1 clear in reset", row_clr, 64'd0);
      chk("R1 busy in reset", 64'(busy), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 gate after reset", row_gate, 64'd0);
      chk("R1 samples after reset", 64'({smp_full, smp_empty}), 64'd0);
      chk("R1 pulses after reset", 64'({scan_done, chain_out, busy}), 64'd0);

      // R1/R4: empty store, every row is a single ending cycle
      run_scan(5, 2, 1'b1, 1'b0, 1'b0);

      // R2 program: gate, full sample, clear, clear+empty (masked, R5), empty, off, end
      put_step(0, 4'h1, 2);
      put_step(1, 4'h5, 3);
      put_step(2, 4'h3, 2);
      put_step(3, 4'hB, 1);
      put_step(4, 4'h9, 2);
      put_step(5, 4'h0, 1);
      put_step(6, 4'h3, 0);
      put_step(7, 4'h3, 4);   // R4: after the terminator, never played

      run_scan(0, 3, 1'b1, 1'b0, 1'b1);    // R7 + R11 busy poke
      run_scan(60, 3, 1'b1, 1'b0, 1'b0);   // R8 ends exactly at row 63
      run_scan(62, 5, 1'b1, 1'b0, 1'b0);   // R9 runs past row 63
      run_scan(63, 0, 1'b1, 1'b0, 1'b0);   // R8 single last row
      run_scan(0, 0, 1'b0, 1'b1, 1'b0);    // R10 chain scan over all rows
      run_scan(20, 1, 1'b1, 1'b1, 1'b0);   // R11 scan_go wins over chain_in

      // R4: all sixteen steps used, row ends after step 15
      for (int s = 0; s < NS; s++) begin
         put_step(s, 1 | ((s % 4 == 1) ? 4 : (s % 4 == 2) ? 2 : (s % 4 == 3) ? 8 : 0),
                  (s % 3) + 1);
      end
      run_scan(10, 1, 1'b1, 1'b0, 1'b0);
      run_scan(40, 63, 1'b1, 1'b0, 1'b0);  // R9 large count truncated at 63

      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule